// File: doc/BRIEF.md
# Operand and Branch Address Generator

This unit sits beside the decoder of a small 8-bit processor with a 16-bit address space. Each operation is started with a one-cycle `startOp` pulse carrying a decoded addressing mode, an operand size, an 8-bit and a 16-bit instruction field, the address of the following instruction and one value read from the register file. The unit returns one of three things: the effective address of a memory operand, a branch target, or an immediate operand. For the pre-decrement mode it also returns the value to write back to the register.

Most modes finish one cycle after the start. The indirect mode takes two phases. First the unit issues a pointer read into the lowest 256-byte page. The word that comes back then becomes the branch target. Mode and size pairs that have no meaning are reported with an error flag and produce no register update.

Top module: `eaUnit`

## Requirements
- R1: After reset, `resultValid`, `errFlag`, `regWrEn` and `ptrReq` are 0, and `effAddr`, `opValue` and `ptrAddr` are 0.
- R2: Short absolute mode (`modeSel` = 0) gives `effAddr` = {8'hFF, fieldShort}.
- R3: Long absolute mode (`modeSel` = 1) gives `effAddr` = `fieldLong`.
- R4: Short immediate (`modeSel` = 2) gives `opValue` = {8'h00, fieldShort} for either size. Long immediate (`modeSel` = 3) gives `opValue` = `fieldLong` and is legal only with word size. Both immediate modes return `effAddr` = 0.
- R5: Implicit-constant mode (`modeSel` = 7) gives `opValue` = 1 for byte size and 2 for word size. Every completed legal operation returns `bitNum` = fieldShort[2:0].
- R6: PC-relative mode (`modeSel` = 4, word size only) gives `effAddr` = nextPc + sign-extended fieldShort, modulo 2^16.
- R7: Pre-decrement mode (`modeSel` = 6) gives `regWrData` = regVal − 1 for byte size or regVal − 2 for word size, modulo 2^16, and `effAddr` equals that value. `regWrEn` is high for exactly the one cycle in which that result is valid.
- R8: For word size (`wordSize` = 1), every address result (R2, R3, R6, R7 and R10) has bit 0 forced to 0. Byte-size addresses keep bit 0.
- R9: Indirect mode (`modeSel` = 5, word size only) raises `ptrReq` one cycle after the start, with `ptrAddr` = {8'h00, fieldShort[7:1], 1'b0}. Both hold steady until `ptrValid` is sampled high.
- R10: One cycle after `ptrValid` is sampled with `ptrReq` high, `resultValid` pulses, `ptrReq` drops, and `effAddr` = ptrData with bit 0 cleared, with `opValue` = 0.
- R11: Long immediate, PC-relative or indirect with byte size sets `errFlag` together with `resultValid`. In that case `regWrEn` stays 0 and `effAddr`, `opValue` and `bitNum` read 0.
- R12: A `startOp` that arrives while a pointer read is pending is ignored. This holds even in the same cycle as `ptrValid`: no extra result, no write-back.
- R13: `resultValid` is a one-cycle strobe per operation. A new `startOp` is accepted in the cycle in which the previous result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startOp | input | 1 | Start pulse for one operation |
| modeSel | input | 3 | Addressing mode code (0..7, see requirements) |
| wordSize | input | 1 | 1 = word operand, 0 = byte operand |
| fieldShort | input | 8 | 8-bit instruction field |
| fieldLong | input | 16 | 16-bit instruction field |
| nextPc | input | 16 | Address of the following instruction |
| regVal | input | 16 | Register-file read value |
| ptrValid | input | 1 | Pointer word on ptrData is valid |
| ptrData | input | 16 | Pointer word read from memory |
| resultValid | output | 1 | Result strobe |
| errFlag | output | 1 | Illegal mode/size pair, valid with resultValid |
| effAddr | output | 16 | Effective address or branch target |
| opValue | output | 16 | Immediate or implicit operand |
| bitNum | output | 3 | Bit-number immediate |
| regWrEn | output | 1 | Register write-back enable |
| regWrData | output | 16 | Register write-back value |
| ptrReq | output | 1 | Pointer read request |
| ptrAddr | output | 16 | Pointer read address |

## Verification
Two pairs of events can share a cycle. The completion of a pending pointer read can meet a fresh start request. A result strobe can also meet the start of the next operation. Every indirect operation drives `startOp` with a pre-decrement mode during each wait cycle, and odd-numbered sweep points also drive it in the same cycle as `ptrValid`. The bench then checks that exactly one result appears, that it carries the fetched target, and that no write-back follows. Back-to-back pre-decrement pairs hold `startOp` high across two edges, and each of the two results and write-back strobes is compared against arithmetic computed in the bench.

// File: rtl/eaPkg.sv
package eaPkg;

  typedef enum logic [2:0] {
    MD_ABS_S    = 3'd0,
    MD_ABS_L    = 3'd1,
    MD_IMM_S    = 3'd2,
    MD_IMM_L    = 3'd3,
    MD_PCREL    = 3'd4,
    MD_MEMIND   = 3'd5,
    MD_PREDEC   = 3'd6,
    MD_IMPLICIT = 3'd7
  } eaMode_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic loadDirect;
    logic loadPtr;
    logic loadFetched;
    logic clearData;
  } eaStrobe_t;

  function automatic logic illegalCombo(input eaMode_e m, input logic w);
    return !w && (m == MD_IMM_L || m == MD_PCREL || m == MD_MEMIND);
  endfunction

endpackage

// File: rtl/eaCtrl.sv
module eaCtrl
  import eaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startOp,
  input  logic [2:0] modeSel,
  input  logic      wordSize,
  input  logic      ptrValid,
  output eaStrobe_t strb,
  output logic      resultValid,
  output logic      errFlag,
  output logic      regWrEn,
  output logic      ptrReq
);

  typedef enum logic {ST_IDLE, ST_FETCH} ctlState_e;

  ctlState_e state;
  eaMode_e   mode;
  logic      accept;
  logic      bad;

  always_comb begin
    mode             = eaMode_e'(modeSel);
    accept           = startOp && (state == ST_IDLE);
    bad              = illegalCombo(mode, wordSize);
    strb.loadDirect  = accept && !bad && (mode != MD_MEMIND);
    strb.loadPtr     = accept && !bad && (mode == MD_MEMIND);
    strb.loadFetched = (state == ST_FETCH) && ptrValid;
    strb.clearData   = accept && bad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      resultValid <= 1'b0;
      errFlag     <= 1'b0;
      regWrEn     <= 1'b0;
    end else begin
      if (strb.loadPtr)          state <= ST_FETCH;
      else if (strb.loadFetched) state <= ST_IDLE;
      resultValid <= strb.loadDirect || strb.clearData || strb.loadFetched;
      errFlag     <= strb.clearData;
      regWrEn     <= strb.loadDirect && (mode == MD_PREDEC);
    end
  end

  assign ptrReq = (state == ST_FETCH);

  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !regWrEn); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> resultValid && !errFlag); // R7
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReq && ptrValid) |=> (resultValid && !ptrReq && !errFlag && !regWrEn)); // R10
  AST_NO_DONE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    ptrReq |-> !resultValid); // R12

endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  eaStrobe_t                  strb,
  input  logic [2:0]                 modeSel,
  input  logic                       wordSize,
  input  logic [FIELD_W-1:0]         fieldShort,
  input  logic [ADDR_W-1:0]          fieldLong,
  input  logic [ADDR_W-1:0]          nextPc,
  input  logic [ADDR_W-1:0]          regVal,
  input  logic [ADDR_W-1:0]          ptrData,
  output logic [ADDR_W-1:0]          effAddr,
  output logic [ADDR_W-1:0]          opValue,
  output logic [$clog2(FIELD_W)-1:0] bitNum,
  output logic [ADDR_W-1:0]          regWrData,
  output logic [ADDR_W-1:0]          ptrAddr
);

  localparam int PAGE_W = ADDR_W - FIELD_W;
  localparam int BIT_W  = $clog2(FIELD_W);
  localparam logic [PAGE_W-1:0] TOP_PAGE  = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] ZERO_PAGE = '0;

  function automatic logic [ADDR_W-1:0] alignIf(input logic [ADDR_W-1:0] a, input logic w);
    return w ? {a[ADDR_W-1:1], 1'b0} : a;
  endfunction

  eaMode_e            mode;
  logic [ADDR_W-1:0]  decVal;
  logic [ADDR_W-1:0]  sextDisp;
  logic [ADDR_W-1:0]  candEa;
  logic [ADDR_W-1:0]  candOp;

  always_comb begin
    mode     = eaMode_e'(modeSel);
    decVal   = regVal - (wordSize ? ADDR_W'(2) : ADDR_W'(1));
    sextDisp = {{PAGE_W{fieldShort[FIELD_W-1]}}, fieldShort};
    candEa   = '0;
    candOp   = '0;
    case (mode)
      MD_ABS_S:    candEa = alignIf({TOP_PAGE, fieldShort}, wordSize);
      MD_ABS_L:    candEa = alignIf(fieldLong, wordSize);
      MD_IMM_S:    candOp = {ZERO_PAGE, fieldShort};
      MD_IMM_L:    candOp = fieldLong;
      MD_PCREL:    candEa = alignIf(nextPc + sextDisp, 1'b1);
      MD_PREDEC:   candEa = alignIf(decVal, wordSize);
      MD_IMPLICIT: candOp = wordSize ? ADDR_W'(2) : ADDR_W'(1);
      default:     candEa = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr   <= '0;
      opValue   <= '0;
      bitNum    <= '0;
      regWrData <= '0;
      ptrAddr   <= '0;
    end else begin
      if (strb.loadDirect) begin
        effAddr <= candEa;
        opValue <= candOp;
        bitNum  <= fieldShort[BIT_W-1:0];
        if (mode == MD_PREDEC) regWrData <= decVal;
      end
      if (strb.loadPtr) begin
        ptrAddr <= {ZERO_PAGE, fieldShort[FIELD_W-1:1], 1'b0};
        bitNum  <= fieldShort[BIT_W-1:0];
      end
      if (strb.loadFetched) begin
        effAddr <= alignIf(ptrData, 1'b1);
        opValue <= '0;
      end
      if (strb.clearData) begin
        effAddr <= '0;
        opValue <= '0;
        bitNum  <= '0;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R12

endmodule

// File: rtl/eaUnit.sv
module eaUnit
  import eaPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startOp,
  input  logic [2:0]                 modeSel,
  input  logic                       wordSize,
  input  logic [FIELD_W-1:0]         fieldShort,
  input  logic [ADDR_W-1:0]          fieldLong,
  input  logic [ADDR_W-1:0]          nextPc,
  input  logic [ADDR_W-1:0]          regVal,
  input  logic                       ptrValid,
  input  logic [ADDR_W-1:0]          ptrData,
  output logic                       resultValid,
  output logic                       errFlag,
  output logic [ADDR_W-1:0]          effAddr,
  output logic [ADDR_W-1:0]          opValue,
  output logic [$clog2(FIELD_W)-1:0] bitNum,
  output logic                       regWrEn,
  output logic [ADDR_W-1:0]          regWrData,
  output logic                       ptrReq,
  output logic [ADDR_W-1:0]          ptrAddr
);

  localparam int PAGE_W = ADDR_W - FIELD_W;

  eaStrobe_t strb;

  eaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startOp(startOp), .modeSel(modeSel),
    .wordSize(wordSize), .ptrValid(ptrValid), .strb(strb),
    .resultValid(resultValid), .errFlag(errFlag), .regWrEn(regWrEn),
    .ptrReq(ptrReq)
  );

  eaDatapath #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .modeSel(modeSel),
    .wordSize(wordSize), .fieldShort(fieldShort), .fieldLong(fieldLong),
    .nextPc(nextPc), .regVal(regVal), .ptrData(ptrData),
    .effAddr(effAddr), .opValue(opValue), .bitNum(bitNum),
    .regWrData(regWrData), .ptrAddr(ptrAddr)
  );

  AST_PTR_ZERO_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    ptrReq |-> (ptrAddr[ADDR_W-1:FIELD_W] == PAGE_W'(0)) && !ptrAddr[0]); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReq && $past(ptrReq)) |-> $stable(ptrAddr)); // R9
  AST_WB_MATCHES_EA: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (effAddr[ADDR_W-1:1] == regWrData[ADDR_W-1:1])); // R7

endmodule

// File: tb/tb_eaUnit.sv
module tb_eaUnit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startOp = 1'b0;
  logic [2:0]  modeSel = '0;
  logic        wordSize = 1'b0;
  logic [7:0]  fieldShort = '0;
  logic [15:0] fieldLong = '0;
  logic [15:0] nextPc = '0;
  logic [15:0] regVal = '0;
  logic        ptrValid = 1'b0;
  logic [15:0] ptrData = '0;
  logic        resultValid, errFlag, regWrEn, ptrReq;
  logic [15:0] effAddr, opValue, regWrData, ptrAddr;
  logic [2:0]  bitNum;

  int nCmp = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eaUnit dut (
    .clk(clk), .rstN(rstN), .startOp(startOp), .modeSel(modeSel),
    .wordSize(wordSize), .fieldShort(fieldShort), .fieldLong(fieldLong),
    .nextPc(nextPc), .regVal(regVal), .ptrValid(ptrValid), .ptrData(ptrData),
    .resultValid(resultValid), .errFlag(errFlag), .effAddr(effAddr),
    .opValue(opValue), .bitNum(bitNum), .regWrEn(regWrEn),
    .regWrData(regWrData), .ptrReq(ptrReq), .ptrAddr(ptrAddr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] memWord(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h35};
  endfunction

  // expected results computed from the requirements
  task automatic expect_op(input int m, input logic w, input logic [7:0] fs,
                           input logic [15:0] fl, input logic [15:0] pc,
                           input logic [15:0] rv, output logic err,
                           output logic [15:0] ea, output logic [15:0] op,
                           output logic [15:0] wb);
    logic [15:0] t;
    err = !w && (m == 3 || m == 4 || m == 5);
    ea = 16'h0; op = 16'h0; wb = 16'h0;
    case (m)
      0: ea = {8'hFF, fs};
      1: ea = fl;
      2: op = {8'h00, fs};
      3: op = fl;
      4: begin t = pc + {{8{fs[7]}}, fs}; ea = {t[15:1], 1'b0}; end
      6: begin wb = rv - (w ? 16'd2 : 16'd1); ea = wb; end
      7: op = w ? 16'd2 : 16'd1;
      default: ;
    endcase
    if (w) ea[0] = 1'b0;
    if (err) begin ea = 16'h0; op = 16'h0; end
  endtask

  task automatic setIn(input int m, input logic w, input logic [7:0] fs,
                       input logic [15:0] fl, input logic [15:0] pc, input logic [15:0] rv);
    modeSel = m[2:0]; wordSize = w; fieldShort = fs;
    fieldLong = fl; nextPc = pc; regVal = rv;
  endtask

  task automatic checkResult(input int m, input logic w, input logic [7:0] fs,
                             input logic [15:0] fl, input logic [15:0] pc, input logic [15:0] rv);
    logic e; logic [15:0] ea, op, wb;
    expect_op(m, w, fs, fl, pc, rv, e, ea, op, wb);
    check("R13 resultValid", {15'h0, resultValid}, 16'h1);
    check("R11 errFlag", {15'h0, errFlag}, {15'h0, e});
    check(m == 0 ? "R2 effAddr" : m == 1 ? "R3 effAddr" : m == 4 ? "R6 effAddr" :
          m == 6 ? "R7 effAddr" : "R8/R11 effAddr", effAddr, ea);
    check((m == 2 || m == 3) ? "R4 opValue" : m == 7 ? "R5 opValue" : "R11 opValue", opValue, op);
    check("R5 bitNum", {13'h0, bitNum}, e ? 16'h0 : {13'h0, fs[2:0]});
    check("R7 regWrEn", {15'h0, regWrEn}, {15'h0, (m == 6) && !e});
    if (m == 6 && !e) check("R7 regWrData", regWrData, wb);
  endtask

  task automatic directOp(input int m, input logic w, input logic [7:0] fs,
                          input logic [15:0] fl, input logic [15:0] pc, input logic [15:0] rv);
    @(negedge clk); setIn(m, w, fs, fl, pc, rv); startOp = 1'b1;
    @(negedge clk); startOp = 1'b0;
    checkResult(m, w, fs, fl, pc, rv);
    @(negedge clk);
    check("R13 strobe drops", {15'h0, resultValid}, 16'h0);
    check("R7 single wb cycle", {15'h0, regWrEn}, 16'h0);
  endtask

  task automatic indirectOp(input logic [7:0] fs, input int lat, input logic collide);
    logic [15:0] pa, tgt;
    pa = {8'h00, fs[7:1], 1'b0};
    tgt = memWord(pa);
    @(negedge clk); setIn(5, 1'b1, fs, 16'h1234, 16'h2000, 16'h0100); startOp = 1'b1;
    @(negedge clk); startOp = 1'b0;
    check("R9 ptrReq", {15'h0, ptrReq}, 16'h1);
    check("R9 ptrAddr", ptrAddr, pa);
    check("R9 no early result", {15'h0, resultValid}, 16'h0);
    for (int k = 0; k < lat; k++) begin
      modeSel = 3'd6; startOp = 1'b1;
      @(negedge clk); startOp = 1'b0;
      check("R12 ptrReq held", {15'h0, ptrReq}, 16'h1);
      check("R9 ptrAddr held", ptrAddr, pa);
      check("R12 start ignored", {15'h0, resultValid | regWrEn}, 16'h0);
    end
    ptrValid = 1'b1; ptrData = tgt; modeSel = 3'd6; startOp = collide;
    @(negedge clk); ptrValid = 1'b0; startOp = 1'b0; ptrData = 16'hDEAD;
    check("R10 resultValid", {15'h0, resultValid}, 16'h1);
    check("R10 errFlag", {15'h0, errFlag}, 16'h0);
    check("R10 ptrReq drops", {15'h0, ptrReq}, 16'h0);
    check("R10 effAddr", effAddr, {tgt[15:1], 1'b0});
    check("R10 opValue", opValue, 16'h0);
    check("R5 bitNum", {13'h0, bitNum}, {13'h0, fs[2:0]});
    check("R12 no wb", {15'h0, regWrEn}, 16'h0);
    @(negedge clk);
    check("R12 no extra result", {15'h0, resultValid | regWrEn | ptrReq}, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog R9: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 resultValid", {15'h0, resultValid}, 16'h0);
    check("R1 errFlag", {15'h0, errFlag}, 16'h0);
    check("R1 regWrEn", {15'h0, regWrEn}, 16'h0);
    check("R1 ptrReq", {15'h0, ptrReq}, 16'h0);
    check("R1 effAddr", effAddr, 16'h0);
    check("R1 opValue", opValue, 16'h0);
    check("R1 ptrAddr", ptrAddr, 16'h0);

    for (int i = 0; i < 18; i++) begin
      logic [7:0] fs;
      logic [15:0] fl, pc, rv;
      fs = (i < 16) ? 8'(i * 17) : (i == 16 ? 8'h7F : 8'h80);
      fl = {fs, fs ^ 8'h3C};
      pc = (i == 0) ? 16'h0010 : (i == 17) ? 16'h0040 : 16'(16'hFFC0 + i * 16'd37);
      rv = {fs ^ 8'h0F, fs};
      for (int m = 0; m < 8; m++) begin
        for (int w = 0; w < 2; w++) begin
          if (m == 5 && w == 1) indirectOp(fs, i % 4, i[0]);
          else directOp(m, w[0], fs, fl, pc, rv);
        end
      end
    end

    // R13: back-to-back pre-decrements, second start in the result cycle
    for (int j = 0; j < 4; j++) begin
      logic [15:0] r1, r2;
      r1 = 16'(j * 16'h1111);
      r2 = 16'(16'h8001 + j * 3);
      @(negedge clk); setIn(6, j[0], 8'(j), 16'h0, 16'h0, r1); startOp = 1'b1;
      @(negedge clk);
      checkResult(6, j[0], 8'(j), 16'h0, 16'h0, r1);
      setIn(6, !j[0], 8'(j + 5), 16'h0, 16'h0, r2); startOp = 1'b1;
      @(negedge clk); startOp = 1'b0;
      checkResult(6, !j[0], 8'(j + 5), 16'h0, 16'h0, r2);
      @(negedge clk);
      check("R13 strobe drops after pair", {15'h0, resultValid | regWrEn}, 16'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule